// File: doc/BRIEF.md
# Privilege-Checking Coprocessor Handshake Responder

This block is the front end of a coprocessor. It watches the instruction stream that a host processor offers and decides, for each offered word, whether this coprocessor will take it. Each time the host pulses its instruction-valid strobe, the block captures the instruction word and a mode flag. It extracts the coprocessor number and the operation code, then drives a two-wire reply back to the host. The reply either claims the instruction or reports that no coprocessor is present. In the second case the host raises its undefined-instruction trap, and software can emulate the operation.

The reply rejects an instruction in three cases: it is addressed to a different coprocessor number, its operation code is not implemented, or it needs privilege but arrived while the host ran in user mode. All three cases use the same "absent" reply. If an accepted operation moves data from the coprocessor to the host, the block presents the data on its output bus and raises the bus enable for exactly one cycle. The arithmetic datapath and the register file behind it are outside this block.

Top module: `cop_gate`

## Requirements
- R1: While `rst` is high at a clock edge, both reply wires go high after that edge, `data_oe` goes low and `data_out` goes to zero.
- R2: If `instr_valid` is high at an edge, the instruction is claimed when three conditions hold: bits [11:8] equal `CP_ID`, the operation code in bits [23:20] is implemented, and privilege allows it. A claimed instruction drives both reply wires low after that same edge.
- R3: If bits [11:8] of a strobed word differ from `CP_ID`, both reply wires are high after the strobe edge, whatever the mode and operation code.
- R4: If the operation code's bit in `IMPL_MASK` is zero, both reply wires are high after the strobe edge, in either mode.
- R5: `priv_mode` low means user mode and high means privileged mode. If the operation code's bit in `PRIV_MASK` is set and `priv_mode` is low, both reply wires are high. The same word with `priv_mode` high is claimed.
- R6: The reply holds its value until the next strobe. Changes on `instr_word` or `priv_mode` while `instr_valid` is low have no effect.
- R7: A claimed operation whose bit in `STORE_MASK` is set raises `data_oe` for exactly one cycle, starting at the second edge after the strobe. During that cycle `data_out` carries the value that `src_data` had at that edge.
- R8: At all other times `data_oe` is low and `data_out` is zero. This includes rejected instructions with a store opcode and claimed instructions without one.
- R9: Only the `priv_mode` value present at the strobe edge counts. A change to `priv_mode` after that edge leaves both the reply and any pending data cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Strobe marking a new instruction offer |
| instr_word | input | INSTR_W | Offered instruction word |
| priv_mode | input | 1 | 0 = user mode, 1 = privileged mode |
| src_data | input | DATA_W | Value to present on the data cycle of a store operation |
| hs_a | output | 1 | Reply wire A (low with B low = claimed; both high = absent) |
| hs_b | output | 1 | Reply wire B |
| data_oe | output | 1 | Data bus enable, high only on the data cycle |
| data_out | output | DATA_W | Output data, zero when not enabled |

## Verification
The hardest situation to reach is two strobes in consecutive cycles, where the first claims a store and the second is rejected. The data cycle of the first instruction must still appear even though the reply has already switched to absent. The bench issues exactly that pair of strobes. It also asserts reset in the cycle between a claimed store's strobe and its data cycle, to show that the pending data cycle is dropped. Changing the mode and the word right after every table strobe shows that the reply depends only on the values present at the strobe edge.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;

  localparam int CPN_LSB = 8;
  localparam int OP_LSB  = 20;

  typedef enum logic [1:0] {
    HS_CLAIM  = 2'b00,
    HS_ABSENT = 2'b11
  } hs_reply_e;

  typedef struct packed {
    logic id_hit;
    logic op_known;
    logic op_priv;
    logic op_store;
  } op_class_t;

endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_gate_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CPN_W   = 4,
  parameter int OP_W    = 4,
  parameter logic [CPN_W-1:0]   CP_ID      = 4'd5,
  parameter logic [2**OP_W-1:0] IMPL_MASK  = 16'h00FF,
  parameter logic [2**OP_W-1:0] PRIV_MASK  = 16'h00F0,
  parameter logic [2**OP_W-1:0] STORE_MASK = 16'h0055
) (
  input  logic [INSTR_W-1:0] instr_word,
  output op_class_t          cls
);

  logic [CPN_W-1:0] cpn_f;
  logic [OP_W-1:0]  op_f;
  logic             unused_word;

  assign cpn_f = instr_word[CPN_LSB +: CPN_W];
  assign op_f  = instr_word[OP_LSB +: OP_W];
  assign unused_word = &{1'b0, instr_word};

  always_comb begin
    cls.id_hit   = (cpn_f == CP_ID);
    cls.op_known = IMPL_MASK[op_f];
    cls.op_priv  = PRIV_MASK[op_f];
    cls.op_store = STORE_MASK[op_f];
  end

endmodule

// File: rtl/cop_verdict.sv
module cop_verdict
  import cop_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      instr_valid,
  input  logic      priv_mode,
  input  op_class_t cls,
  output logic      hs_a,
  output logic      hs_b,
  output logic      store_go
);

  logic      claim;
  hs_reply_e reply_q;

  always_comb begin
    claim = cls.id_hit && cls.op_known && (!cls.op_priv || priv_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reply_q  <= HS_ABSENT;
      store_go <= 1'b0;
    end else if (instr_valid) begin
      reply_q  <= claim ? HS_CLAIM : HS_ABSENT;
      store_go <= claim && cls.op_store;
    end else begin
      store_go <= 1'b0;
    end
  end

  assign hs_a = reply_q[1];
  assign hs_b = reply_q[0];

endmodule

// File: rtl/cop_store_phase.sv
module cop_store_phase #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_go,
  input  logic [DATA_W-1:0] src_data,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= store_go;
      data_out <= store_go ? src_data : '0;
    end
  end

endmodule

// File: rtl/cop_gate.sv
module cop_gate
  import cop_gate_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int DATA_W  = 32,
  parameter int CPN_W   = 4,
  parameter int OP_W    = 4,
  parameter logic [CPN_W-1:0]   CP_ID      = 4'd5,
  parameter logic [2**OP_W-1:0] IMPL_MASK  = 16'h00FF,
  parameter logic [2**OP_W-1:0] PRIV_MASK  = 16'h00F0,
  parameter logic [2**OP_W-1:0] STORE_MASK = 16'h0055
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               priv_mode,
  input  logic [DATA_W-1:0]  src_data,
  output logic               hs_a,
  output logic               hs_b,
  output logic               data_oe,
  output logic [DATA_W-1:0]  data_out
);

  op_class_t cls;
  logic      store_go;

  cop_decode #(
    .INSTR_W(INSTR_W), .CPN_W(CPN_W), .OP_W(OP_W), .CP_ID(CP_ID),
    .IMPL_MASK(IMPL_MASK), .PRIV_MASK(PRIV_MASK), .STORE_MASK(STORE_MASK)
  ) u_decode (
    .instr_word(instr_word),
    .cls(cls)
  );

  cop_verdict u_verdict (
    .clk(clk),
    .rst(rst),
    .instr_valid(instr_valid),
    .priv_mode(priv_mode),
    .cls(cls),
    .hs_a(hs_a),
    .hs_b(hs_b),
    .store_go(store_go)
  );

  cop_store_phase #(.DATA_W(DATA_W)) u_store (
    .clk(clk),
    .rst(rst),
    .store_go(store_go),
    .src_data(src_data),
    .data_oe(data_oe),
    .data_out(data_out)
  );

endmodule

// File: rtl/cop_gate_chk.sv
module cop_gate_chk #(
  parameter int DATA_W = 32,
  parameter int CPN_W  = 4,
  parameter int OP_W   = 4,
  parameter logic [CPN_W-1:0]   CP_ID     = 4'd5,
  parameter logic [2**OP_W-1:0] PRIV_MASK = 16'h00F0
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [CPN_W-1:0]  cpn_field,
  input logic [OP_W-1:0]   op_field,
  input logic              priv_mode,
  input logic              hs_a,
  input logic              hs_b,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (hs_a && hs_b && !data_oe && data_out == '0));

  // R2
  reply_pair_chk: assert property (@(posedge clk) disable iff (rst)
    hs_a == hs_b);

  // R3
  foreign_id_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cpn_field != CP_ID) |=> (hs_a && hs_b));

  // R5
  user_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !priv_mode && PRIV_MASK[op_field]) |=> (hs_a && hs_b));

  // R6
  reply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable({hs_a, hs_b}));

  // R7
  oe_single_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |=> !data_oe);

  // R7
  oe_after_claim_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(!hs_a) && $past(!hs_b)));

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == '0);

endmodule

bind cop_gate cop_gate_chk #(
  .DATA_W(DATA_W), .CPN_W(CPN_W), .OP_W(OP_W),
  .CP_ID(CP_ID), .PRIV_MASK(PRIV_MASK)
) u_chk (
  .clk(clk),
  .rst(rst),
  .instr_valid(instr_valid),
  .cpn_field(instr_word[cop_gate_pkg::CPN_LSB +: CPN_W]),
  .op_field(instr_word[cop_gate_pkg::OP_LSB +: OP_W]),
  .priv_mode(priv_mode),
  .hs_a(hs_a),
  .hs_b(hs_b),
  .data_oe(data_oe),
  .data_out(data_out)
);

// File: tb/cop_gate_test.sv
module cop_gate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        priv_mode = 1'b0;
  logic [31:0] src_data = '0;
  logic        hs_a, hs_b, data_oe;
  logic [31:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cop_gate uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .priv_mode(priv_mode), .src_data(src_data), .hs_a(hs_a), .hs_b(hs_b),
    .data_oe(data_oe), .data_out(data_out)
  );

  // vector: {cp[3:0], op[3:0], priv, exp_claim, exp_store}
  // CP_ID=5, implemented ops 0..7, privileged-only ops 4..7, store ops 0,2,4,6
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {4'd5, 4'd0, 1'b0, 1'b1, 1'b1},  // R2 R7 user store
    {4'd5, 4'd1, 1'b0, 1'b1, 1'b0},  // R2 R8 non-store
    {4'd5, 4'd4, 1'b0, 1'b0, 1'b0},  // R5 user on privileged op
    {4'd5, 4'd4, 1'b1, 1'b1, 1'b1},  // R5 privileged store
    {4'd5, 4'd7, 1'b1, 1'b1, 1'b0},  // R5 privileged non-store
    {4'd5, 4'd7, 1'b0, 1'b0, 1'b0},  // R5
    {4'd5, 4'd9, 1'b1, 1'b0, 1'b0},  // R4
    {4'd5, 4'd15, 1'b0, 1'b0, 1'b0}, // R4
    {4'd3, 4'd0, 1'b1, 1'b0, 1'b0},  // R3 R8 rejected store op
    {4'd4, 4'd2, 1'b1, 1'b0, 1'b0},  // R3
    {4'd5, 4'd2, 1'b0, 1'b1, 1'b1},  // R7
    {4'd5, 4'd6, 1'b1, 1'b1, 1'b1}   // R7
  };

  function automatic logic [31:0] mk_word(logic [3:0] cp, logic [3:0] op);
    return {8'hEE, op, 8'h00, cp, 8'h00};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reply(string req, logic claim);
    chk(req, {hs_a, hs_b}, claim ? 2'b00 : 2'b11);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {hs_a, hs_b, data_oe}, 3'b110);
    chk("R1", data_out, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = mk_word(VEC[i][10:7], VEC[i][6:3]);
      priv_mode   = VEC[i][2];
      src_data    = 32'hA500_0000 | i;
      @(negedge clk);
      instr_valid = 1'b0;
      chk_reply(VEC[i][1] ? "R2" : "R3/R4/R5", VEC[i][1]);
      // R6 R9: disturb word and mode without a strobe
      priv_mode  = ~priv_mode;
      instr_word = mk_word(4'd5, 4'd0) ^ {VEC[i][10:7], 28'h0};
      @(negedge clk);
      chk("R7", data_oe, VEC[i][0]);
      chk("R7/R8", data_out, VEC[i][0] ? (32'hA500_0000 | i) : 32'h0);
      chk_reply("R6", VEC[i][1]);
      @(negedge clk);
      chk("R8", {data_oe, data_out}, 33'h0);
      chk_reply("R9", VEC[i][1]);
    end

    // Back-to-back: claimed store then rejected foreign word
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = mk_word(4'd5, 4'd0);
    priv_mode   = 1'b0;
    src_data    = 32'h1234_5678;
    @(negedge clk);
    instr_word  = mk_word(4'd2, 4'd0);
    chk_reply("R2", 1'b1);
    @(negedge clk);
    instr_valid = 1'b0;
    chk_reply("R3", 1'b0);
    chk("R7", data_oe, 1'b1);
    chk("R7", data_out, 32'h1234_5678);
    @(negedge clk);
    chk("R8", {data_oe, data_out}, 33'h0);

    // Long hold with changing inputs and no strobe
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = mk_word(4'd5, 4'd5);
    priv_mode   = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      instr_word = mk_word(k[3:0], 4'd9);
      priv_mode  = k[0];
      @(negedge clk);
      chk_reply("R6", 1'b1);
      chk("R8", data_oe, 1'b0);
    end

    // Reset between a claimed store and its data cycle
    instr_valid = 1'b1;
    instr_word  = mk_word(4'd5, 4'd6);
    priv_mode   = 1'b1;
    src_data    = 32'hDEAD_BEEF;
    @(negedge clk);
    instr_valid = 1'b0;
    chk_reply("R2", 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {hs_a, hs_b, data_oe}, 3'b110);
    chk("R1", data_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {data_oe, data_out}, 33'h0);

    done = 1;
    finish_run();
  end

endmodule